// File: doc/BRIEF.md
# Multilevel to PWM Pattern Encoder

The block turns a stream of quantizer levels into a one-bit pulse stream at the master clock rate. Time is cut into frames of eight clock cycles. Each frame carries one level, and the level sets how many of the eight serial bits in that frame are one. The ones form a single run. That run either starts in the first slot of the frame, or starts at a pseudo-random slot and wraps past the end of the frame, chosen per frame by a rotate control.

A restrict control narrows the level range so that every frame holds at least one one and at least one zero. With rotation also off, every frame then begins high and ends low. The number of edges on the serial line no longer depends on the signal, which suits a non-return-to-zero FIR converter whose tap count is a multiple of eight. A frame-start marker marks the first slot of every frame. New levels are taken only at frame boundaries, and the last level repeats when none is offered.

Top module: `pwm_frame_encoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the encoder returns to slot 0, level 4, offset 0 and LFSR state 0xACE1. During and right after reset, `frame_start_o` is 1 and `bit_o` is 1 for slots 0 to 3 and 0 for slots 4 to 7 of this first frame.
- R2: `frame_start_o` is 1 in slot 0 of every frame and 0 in the other seven slots, so it comes exactly once every eight cycles.
- R3: A frame with level N (0 to 8) holds exactly N one-bits. Input values 9 to 15 saturate to 8.
- R4: While rotation is off at the frame boundary, the ones of level N occupy slots 0 to N-1.
- R5: While rotation is on, the LFSR steps once at every frame boundary. The LFSR is 16-bit Fibonacci: next = {q[14:0], q[15]^q[13]^q[12]^q[10]}. The offset is bits [2:0] of the new state, and slot s is one when ((s - offset) mod 8) < N. The LFSR steps at every boundary even when rotation is off.
- R6: While restrict is on at a boundary, the level taken for the new frame is clamped to the range 1 to 7. An input of 0 becomes 1, and an input of 8 or more becomes 7. A repeated level is clamped in the same way.
- R7: Level, valid, rotate and restrict are sampled only at the rising edge that ends slot 7. Values offered at any other edge have no effect.
- R8: If `level_valid_i` is low at a boundary, the next frame reuses the previous frame's level, clamped according to R6.
- R9: With restrict on and rotation off, each frame starts with a one and ends with a zero, giving exactly two transitions of `bit_o` per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| level_i | input | 4 | Quantizer level for the next frame |
| level_valid_i | input | 1 | Qualifies `level_i` at a frame boundary |
| rotate_en_i | input | 1 | 1 = random start offset, 0 = ones at frame start |
| restrict_i | input | 1 | 1 = limit levels to 1..7 |
| bit_o | output | 1 | Serial pulse stream |
| frame_start_o | output | 1 | High in slot 0 of each frame |

## Verification
The inputs are sampled at the edge that ends slot 7. The resulting pattern is visible from the very next cycle and lasts eight cycles. `frame_start_o` and `bit_o` are combinational on registered state, so they are valid one clock after that edge. The bench keeps its own slot count. It drives the inputs on the falling edge inside slot 7, then reads the eight following slots on falling edges and compares them with a pattern computed from its own LFSR and clamp model. During slots 0 to 6, the bench deliberately drives the inputs with other values to show that those values do not reach the following frame.

// File: rtl/pwm_enc_pkg.sv
// Package: shared defaults and types for the PWM frame encoder.
// Assumes the frame length is a power of two.
package pwm_enc_pkg;

    localparam int DEF_FRAME_LEN = 8;
    localparam int DEF_LFSR_W    = 16;
    localparam logic [15:0] DEF_LFSR_TAPS = 16'hB400;
    localparam logic [15:0] DEF_LFSR_SEED = 16'hACE1;

    typedef enum logic {
        RANGE_FULL       = 1'b0,
        RANGE_RESTRICTED = 1'b1
    } range_mode_e;

endpackage

// File: rtl/pwm_slot_timer.sv
// Module: slot counter that divides the clock into frames.
// Assumes FRAME_LEN is a power of two; slot wraps naturally.
module pwm_slot_timer #(
    parameter int FRAME_LEN = 8,
    localparam int SLOT_W   = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic              frame_start_o,
    output logic              frame_end_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

    logic [SLOT_W-1:0] slot_q;

    // Advance slot every cycle; reset returns to slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Decode frame boundary markers.
    always_comb begin
        slot_o        = slot_q;
        frame_start_o = (slot_q == '0);
        frame_end_o   = (slot_q == LAST_SLOT);
    end

endmodule

// File: rtl/pwm_level_hold.sv
// Module: takes a new level at frame end, or repeats the held one,
// then clamps it to the range that the restrict control allows.
// Assumes frame_end_i is high for one cycle per frame.
module pwm_level_hold
    import pwm_enc_pkg::*;
#(
    parameter int FRAME_LEN = 8,
    localparam int LVL_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             level_valid_i,
    input  logic             restrict_i,
    output logic [LVL_W-1:0] level_o
);

    localparam logic [LVL_W-1:0] FULL_MAX  = LVL_W'(FRAME_LEN);
    localparam logic [LVL_W-1:0] RSTR_MAX  = LVL_W'(FRAME_LEN - 1);
    localparam logic [LVL_W-1:0] RSTR_MIN  = LVL_W'(1);
    localparam logic [LVL_W-1:0] RESET_LVL = LVL_W'(FRAME_LEN / 2);

    logic [LVL_W-1:0] level_q;
    logic [LVL_W-1:0] raw_next;
    logic [LVL_W-1:0] sat_next;
    logic [LVL_W-1:0] clamped_next;
    range_mode_e      mode;

    // Choose fresh or repeated level and apply the range limits.
    always_comb begin
        mode     = restrict_i ? RANGE_RESTRICTED : RANGE_FULL;
        raw_next = level_valid_i ? level_i : level_q;
        sat_next = (raw_next > FULL_MAX) ? FULL_MAX : raw_next;
        unique case (mode)
            RANGE_RESTRICTED: begin
                if (sat_next < RSTR_MIN) begin
                    clamped_next = RSTR_MIN;
                end else if (sat_next > RSTR_MAX) begin
                    clamped_next = RSTR_MAX;
                end else begin
                    clamped_next = sat_next;
                end
            end
            default: clamped_next = sat_next;
        endcase
    end

    // Register the level only at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= RESET_LVL;
        end else if (frame_end_i) begin
            level_q <= clamped_next;
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/pwm_rot_lfsr.sv
// Module: Fibonacci LFSR stepped once per frame, plus the start
// offset register that it feeds. Assumes TAPS describes a maximal
// length polynomial and SEED is nonzero.
module pwm_rot_lfsr #(
    parameter int          LFSR_W = 16,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1,
    parameter int          OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end_i,
    input  logic              rotate_en_i,
    output logic [LFSR_W-1:0] lfsr_o,
    output logic [OFF_W-1:0]  offset_o
);

    localparam logic [LFSR_W-1:0] TAP_MASK  = LFSR_W'(TAPS);
    localparam logic [LFSR_W-1:0] SEED_VAL  = LFSR_W'(SEED);

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_step;
    logic [OFF_W-1:0]  offset_q;
    logic              feedback;

    // Compute the next LFSR state from the tap mask.
    always_comb begin
        feedback  = ^(lfsr_q & TAP_MASK);
        lfsr_step = {lfsr_q[LFSR_W-2:0], feedback};
    end

    // Step the LFSR and refresh the offset at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q   <= SEED_VAL;
            offset_q <= '0;
        end else if (frame_end_i) begin
            lfsr_q   <= lfsr_step;
            offset_q <= rotate_en_i ? lfsr_step[OFF_W-1:0] : '0;
        end
    end

    assign lfsr_o   = lfsr_q;
    assign offset_o = offset_q;

endmodule

// File: rtl/pwm_pattern_gen.sv
// Module: combinational bit for the current slot. A thermometer mask of
// the level is indexed by the slot position relative to the offset.
// Assumes FRAME_LEN is a power of two, so the subtraction wraps.
module pwm_pattern_gen #(
    parameter int FRAME_LEN = 8,
    localparam int SLOT_W   = $clog2(FRAME_LEN),
    localparam int LVL_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [SLOT_W-1:0] offset_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic              bit_o
);

    logic [FRAME_LEN-1:0] thermo;
    logic [SLOT_W-1:0]    rel_pos;

    // Thermometer code: position i is one when i is below the level.
    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_thermo
        assign thermo[i] = (LVL_W'(i) < level_i);
    end

    // Select the bit for the slot's position within the rotated run.
    always_comb begin
        rel_pos = slot_i - offset_i;
        bit_o   = thermo[rel_pos];
    end

endmodule

// File: rtl/pwm_frame_encoder.sv
// Module: top of the multilevel to PWM encoder. Each level fills one
// frame of FRAME_LEN cycles with a single run of ones, optionally at a
// pseudo-random start slot. Assumes FRAME_LEN is a power of two and
// LFSR_W is at least log2(FRAME_LEN).
module pwm_frame_encoder
    import pwm_enc_pkg::*;
#(
    parameter int          FRAME_LEN = DEF_FRAME_LEN,
    parameter int          LFSR_W    = DEF_LFSR_W,
    parameter logic [15:0] LFSR_TAPS = DEF_LFSR_TAPS,
    parameter logic [15:0] LFSR_SEED = DEF_LFSR_SEED,
    localparam int SLOT_W = $clog2(FRAME_LEN),
    localparam int LVL_W  = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    input  logic             level_valid_i,
    input  logic             rotate_en_i,
    input  logic             restrict_i,
    output logic             bit_o,
    output logic             frame_start_o
);

    logic [SLOT_W-1:0] slot;
    logic              frame_end;
    logic [LVL_W-1:0]  level_q;
    logic [SLOT_W-1:0] offset_q;
    logic [LFSR_W-1:0] lfsr_q;

    pwm_slot_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_o       (slot),
        .frame_start_o(frame_start_o),
        .frame_end_o  (frame_end)
    );

    pwm_level_hold #(.FRAME_LEN(FRAME_LEN)) u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_end_i  (frame_end),
        .level_i      (level_i),
        .level_valid_i(level_valid_i),
        .restrict_i   (restrict_i),
        .level_o      (level_q)
    );

    pwm_rot_lfsr #(
        .LFSR_W(LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED),
        .OFF_W (SLOT_W)
    ) u_rot (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end_i(frame_end),
        .rotate_en_i(rotate_en_i),
        .lfsr_o     (lfsr_q),
        .offset_o   (offset_q)
    );

    pwm_pattern_gen #(.FRAME_LEN(FRAME_LEN)) u_pat (
        .slot_i  (slot),
        .offset_i(offset_q),
        .level_i (level_q),
        .bit_o   (bit_o)
    );

endmodule

// File: rtl/pwm_enc_checker.sv
// Module: assertion checker bound into the encoder top.
// Assumes frames of FRAME_LEN cycles with frame_start_o in slot 0.
module pwm_enc_checker #(
    parameter int FRAME_LEN = 8,
    parameter int LFSR_W    = 16,
    localparam int SLOT_W   = $clog2(FRAME_LEN),
    localparam int LVL_W    = $clog2(FRAME_LEN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_o,
    input logic              frame_start_o,
    input logic              rotate_en_i,
    input logic              restrict_i,
    input logic [LVL_W-1:0]  lvl_q,
    input logic [SLOT_W-1:0] off_q,
    input logic [LFSR_W-1:0] lfsr_q
);

    logic [LVL_W-1:0] ones_cnt;
    logic [LVL_W-1:0] lvl_seen;
    logic             armed;

    // Count ones across each frame and remember the frame's level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_cnt <= '0;
            lvl_seen <= '0;
            armed    <= 1'b0;
        end else if (frame_start_o) begin
            ones_cnt <= LVL_W'(bit_o);
            lvl_seen <= lvl_q;
            armed    <= 1'b1;
        end else begin
            ones_cnt <= ones_cnt + LVL_W'(bit_o);
        end
    end

    assert_frame_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

    assert_ones_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && armed) |-> (ones_cnt == lvl_seen));

    assert_no_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && !$past(rotate_en_i)) |-> (off_q == '0));

    assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    assert_restrict_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && $past(restrict_i)) |->
            (lvl_q >= LVL_W'(1) && lvl_q <= LVL_W'(FRAME_LEN - 1)));

    assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_o |-> $stable(lvl_q));

    assert_starts_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && $past(restrict_i) && !$past(rotate_en_i)) |-> bit_o);

endmodule

bind pwm_frame_encoder pwm_enc_checker #(
    .FRAME_LEN(FRAME_LEN),
    .LFSR_W   (LFSR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_o        (bit_o),
    .frame_start_o(frame_start_o),
    .rotate_en_i  (rotate_en_i),
    .restrict_i   (restrict_i),
    .lvl_q        (level_q),
    .off_q        (offset_q),
    .lfsr_q       (lfsr_q)
);

// File: tb/sim_pwm_frame_encoder.sv
// Bench: sweeps every level under each rotate/restrict combination and
// compares each frame with a pattern computed arithmetically.
module sim_pwm_frame_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] level_i = '0;
    logic       level_valid_i = 1'b0;
    logic       rotate_en_i = 1'b1;
    logic       restrict_i = 1'b0;
    logic       bit_o;
    logic       frame_start_o;

    int          n_tests = 0;
    int          n_fail = 0;
    logic [15:0] m_lfsr;
    int          m_lvl;
    int          m_off;
    logic        prev_bit;
    bit          prev_fixed_edges;

    pwm_frame_encoder u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_i      (level_i),
        .level_valid_i(level_valid_i),
        .rotate_en_i  (rotate_en_i),
        .restrict_i   (restrict_i),
        .bit_o        (bit_o),
        .frame_start_o(frame_start_o)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [15:0] lfsr_next(logic [15:0] q);
        return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

    function automatic int clamp_lvl(int v, bit rstr);
        int r = (v > 8) ? 8 : v;
        if (rstr) begin
            if (r < 1) r = 1;
            if (r > 7) r = 7;
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Entered at the falling edge inside slot 7; leaves at the same point
    // of the next frame. junk drives other inputs during slots 0..6 (R7).
    task automatic run_frame(int lvl, bit vld, bit rot, bit rstr, bit junk, string tag);
        int  act_pat = 0;
        int  exp_pat = 0;
        int  fs_pat  = 0;
        int  ones    = 0;
        int  edges   = 0;
        bit  fixed_mode;
        level_i       = 4'(lvl);
        level_valid_i = vld;
        rotate_en_i   = rot;
        restrict_i    = rstr;
        m_lfsr = lfsr_next(m_lfsr);
        m_off  = rot ? int'(m_lfsr[2:0]) : 0;
        m_lvl  = clamp_lvl(vld ? lvl : m_lvl, rstr);
        fixed_mode = rstr && !rot;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            act_pat[s] = bit_o;
            fs_pat[s]  = frame_start_o;
            exp_pat[s] = (((s - m_off + 8) % 8) < m_lvl);
            ones  += int'(bit_o);
            if (bit_o != prev_bit) edges++;
            prev_bit = bit_o;
            if (s < 7) begin
                if (junk) begin
                    level_i       = ~4'(lvl);
                    level_valid_i = 1'b1;
                    rotate_en_i   = ~rot;
                    restrict_i    = ~rstr;
                end else begin
                    level_valid_i = 1'b0;
                end
            end
        end
        check(act_pat == exp_pat, rot ? "R5" : "R4", {tag, " pattern"}, act_pat, exp_pat);
        check(ones == m_lvl, rstr ? "R6" : "R3", {tag, " ones"}, ones, m_lvl);
        check(fs_pat == 1, "R2", {tag, " frame start"}, fs_pat, 1);
        if (fixed_mode && prev_fixed_edges)
            check(edges == 2, "R9", {tag, " transitions"}, edges, 2);
        prev_fixed_edges = fixed_mode;
    endtask

    initial begin
        prev_fixed_edges = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(frame_start_o == 1'b1, "R1", "reset frame_start", int'(frame_start_o), 1);
        check(bit_o == 1'b1, "R1", "reset bit", int'(bit_o), 1);
        rst_n = 1'b1;
        m_lfsr = 16'hACE1;
        m_lvl = 4;
        m_off = 0;
        prev_bit = 1'b1;
        level_valid_i = 1'b0;
        for (int s = 1; s < 8; s++) begin
            @(negedge clk);
            check(bit_o == (s < 4), "R1", "first frame bit", int'(bit_o), int'(s < 4));
            check(frame_start_o == 1'b0, "R2", "first frame start", int'(frame_start_o), 0);
            prev_bit = bit_o;
        end
        // R3 R4 R5 R6: sweep every input value in every mode
        for (int r = 0; r < 2; r++)
            for (int t = 0; t < 2; t++)
                for (int l = 0; l < 16; l++)
                    run_frame(l, 1'b1, t[0], r[0], 1'b0, "sweep");
        // R8: repeat when no valid level
        run_frame(5, 1'b1, 1'b0, 1'b0, 1'b0, "R8 load");
        run_frame(2, 1'b0, 1'b0, 1'b0, 1'b0, "R8 repeat");
        run_frame(9, 1'b0, 1'b1, 1'b0, 1'b0, "R8 repeat rot");
        // R6: repeated level clamped when restrict turns on
        run_frame(0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 zero");
        run_frame(3, 1'b0, 1'b0, 1'b1, 1'b0, "R6 repeat clamp");
        run_frame(8, 1'b1, 1'b0, 1'b0, 1'b0, "R6 eight");
        run_frame(3, 1'b0, 1'b1, 1'b1, 1'b0, "R6 repeat clamp hi");
        // R7: mid-frame activity ignored
        for (int k = 0; k < 9; k++)
            run_frame(k, 1'b1, k[0], k[1], 1'b1, "R7 junk");
        // R9: fixed edge count with restrict on and rotation off
        for (int k = 0; k < 20; k++)
            run_frame((k * 5) % 10, 1'b1, 1'b0, 1'b1, k[0], "R9 run");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule